// File: doc/BRIEF.md
# SLIC Serial Control Port

This block is the host-facing control port of a subscriber line interface controller. A processor reaches it through five pins: a serial clock, a bidirectional data pin, a direction select, an active-low chip select, and a mode pin. In serial mode the host shifts an 8-bit command word into the block and commits it with the rising edge of chip select. The host can also shift a 5-bit line-status word out of the block. The committed command drives the line-mode logic that lies outside this block. The status bits come from line sensors that are also outside the block.

When the mode pin is high, the chip-select pin stops being an input. It becomes an output that flags an off-hook or ground-key condition to the host. A separate parallel-mode input bypasses the command register. In parallel mode three pins drive the low command bits directly, and two pins report the two lowest status bits in real time.

All pin inputs are treated as already synchronous to the system clock `clk`. Serial clock phases must each last at least one system clock cycle. This easily covers serial rates up to 600 kHz.

Top module: `slic_ctl_port`

## Requirements
- R1: In a serial write frame (chip select low, direction low, neither mode pin high), each rising serial clock samples the data pin. The first bit sampled lands in command bit 0, and the eighth in bit 7.
- R2: The shifted word becomes the command output on the system clock edge that first samples chip select high. It is visible on `cmd_o` after that edge. At no other time does the serial command register change.
- R3: A write frame that contains any number of rising serial clocks other than 8 is discarded, and the command register keeps its value.
- R4: A write frame during which the direction input is seen high at any time is discarded.
- R5: In a read frame (chip select low, direction high, serial mode), the data pin drives status bit 0 first. It advances one bit on each falling serial clock. After all 5 status bits it drives 0. The status word shifted out is the one present on the cycle before the frame starts.
- R6: A read frame may end after fewer than 5 clocks. The next read frame starts again from status bit 0 with fresh status.
- R7: In serial mode the data pin output enable is high only during a read frame. It is low while chip select is high and during write frames.
- R8: With the mode pin high (and parallel mode off), the chip-select output enable is high and `csn_o` equals status bit 0 OR status bit 1. Serial frames have no effect on the command register.
- R9: In parallel mode, `cmd_o` bit 0 follows the direction pin, bit 1 follows the mode pin, and bit 2 follows the serial clock pin, with all higher bits 0. `csn_o` shows status bit 0 and `sdio_o` shows status bit 1, and both enables are high. Leaving parallel mode restores the last serially committed command.
- R10: After reset the command register is 0 and both output enables are low (with serial mode selected and chip select high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin; ring bit in parallel mode |
| sdio_i | input | 1 | Data pin, input side |
| sdio_o | output | 1 | Data pin, output side |
| sdio_oe_o | output | 1 | Data pin output enable |
| dir_i | input | 1 | Direction: 0 write, 1 read; command bit 0 in parallel mode |
| csn_i | input | 1 | Chip select pin, input side (active low) |
| csn_o | output | 1 | Chip select pin, output side |
| csn_oe_o | output | 1 | Chip select pin output enable |
| irq_mode_i | input | 1 | Turns chip select into an alert output; command bit 1 in parallel mode |
| par_mode_i | input | 1 | Selects parallel bypass mode |
| stat_i | input | STAT_W | Line status: bit 0 off-hook, bit 1 ground key |
| cmd_o | output | CMD_W | Active command word |

## Verification
The bench builds the block with its default widths: an 8-bit command and a 5-bit status word. Because the status word is narrow, a 6-clock read frame shifts past the end of the status bits and shows the zero fill. A 9-pulse write frame drives the pulse counter to its saturation value. A 7-pulse frame stops one pulse short of the commit count. Together these two frames bracket the exact-length rule on both sides.

// File: rtl/slic_port_pkg.sv
package slic_port_pkg;

    typedef enum logic [1:0] {
        PM_SERIAL   = 2'd0,
        PM_ALERT    = 2'd1,
        PM_PARALLEL = 2'd2
    } port_mode_e;

    // command bit positions driven directly in parallel mode
    localparam int PB_FEED = 0;
    localparam int PB_TIME = 1;
    localparam int PB_RING = 2;

    // status bit positions used for the alert output
    localparam int SB_HOOK = 0;
    localparam int SB_GKEY = 1;

endpackage

// File: rtl/slic_pin_edges.sv
module slic_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl_i;
        rise_o   = lvl_i & ~s_q.prev;
        fall_o   = ~lvl_i & s_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/slic_cmd_shifter.sv
module slic_cmd_shifter #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en_i,
    input  logic             csn_i,
    input  logic             csn_rise_i,
    input  logic             dir_i,
    input  logic             sdi_i,
    input  logic             sclk_rise_i,
    output logic [CMD_W-1:0] cmd_o
);

    localparam int CNT_W = $clog2(CMD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CMD_W + 1);

    typedef struct packed {
        logic [CMD_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic             bad;
        logic [CMD_W-1:0] cmd;
    } wr_st_t;

    wr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (csn_i) begin
            if (csn_rise_i && !s_q.bad && s_q.cnt == CNT_FULL)
                s_d.cmd = s_q.sh;
            s_d.cnt = '0;
            s_d.bad = 1'b0;
        end else if (!ser_en_i || dir_i) begin
            s_d.bad = 1'b1;
        end else if (sclk_rise_i) begin
            s_d.sh = {sdi_i, s_q.sh[CMD_W-1:1]};
            if (s_q.cnt != CNT_SAT)
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_o = s_q.cmd;

    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !csn_rise_i |=> $stable(s_q.cmd));

    p_len_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_rise_i && s_q.cnt != CNT_FULL) |=> $stable(s_q.cmd));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_SAT);

    p_dir_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_rise_i && s_q.bad) |=> $stable(s_q.cmd));

endmodule

// File: rtl/slic_stat_shifter.sv
module slic_stat_shifter #(
    parameter int STAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_frame_i,
    input  logic              sclk_fall_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              sdo_o
);

    typedef struct packed {
        logic [STAT_W-1:0] sh;
    } rd_st_t;

    rd_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!rd_frame_i)
            s_d.sh = stat_i;
        else if (sclk_fall_i)
            s_d.sh = s_q.sh >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo_o = s_q.sh[0];

    p_shift_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_i && sclk_fall_i) |=> (s_q.sh == ($past(s_q.sh) >> 1)));

    p_shift_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_i && !sclk_fall_i) |=> $stable(s_q.sh));

endmodule

// File: rtl/slic_ctl_port.sv
module slic_ctl_port
    import slic_port_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int STAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    input  logic              dir_i,
    input  logic              csn_i,
    output logic              csn_o,
    output logic              csn_oe_o,
    input  logic              irq_mode_i,
    input  logic              par_mode_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [CMD_W-1:0]  cmd_o
);

    port_mode_e       mode;
    logic             ser_en;
    logic             rd_frame;
    logic             sclk_rise, sclk_fall;
    logic             csn_rise, csn_fall;
    logic [CMD_W-1:0] cmd_q;
    logic [CMD_W-1:0] par_cmd;
    logic             sdo;
    logic             alert;

    always_comb begin
        if (par_mode_i)      mode = PM_PARALLEL;
        else if (irq_mode_i) mode = PM_ALERT;
        else                 mode = PM_SERIAL;
    end

    assign ser_en   = (mode == PM_SERIAL);
    assign rd_frame = ser_en & ~csn_i & dir_i;
    assign alert    = stat_i[SB_HOOK] | stat_i[SB_GKEY];

    slic_pin_edges i_sclk_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sclk_i),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    slic_pin_edges i_csn_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (csn_i),
        .rise_o (csn_rise),
        .fall_o (csn_fall)
    );

    slic_cmd_shifter #(.CMD_W(CMD_W)) i_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_en_i    (ser_en),
        .csn_i       (csn_i),
        .csn_rise_i  (csn_rise),
        .dir_i       (dir_i),
        .sdi_i       (sdio_i),
        .sclk_rise_i (sclk_rise),
        .cmd_o       (cmd_q)
    );

    slic_stat_shifter #(.STAT_W(STAT_W)) i_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_frame_i  (rd_frame),
        .sclk_fall_i (sclk_fall),
        .stat_i      (stat_i),
        .sdo_o       (sdo)
    );

    always_comb begin
        par_cmd          = '0;
        par_cmd[PB_FEED] = dir_i;
        par_cmd[PB_TIME] = irq_mode_i;
        par_cmd[PB_RING] = sclk_i;
    end

    always_comb begin
        case (mode)
            PM_PARALLEL: begin
                cmd_o     = par_cmd;
                sdio_oe_o = 1'b1;
                sdio_o    = stat_i[SB_GKEY];
                csn_oe_o  = 1'b1;
                csn_o     = stat_i[SB_HOOK];
            end
            PM_ALERT: begin
                cmd_o     = cmd_q;
                sdio_oe_o = 1'b0;
                sdio_o    = sdo;
                csn_oe_o  = 1'b1;
                csn_o     = alert;
            end
            default: begin
                cmd_o     = cmd_q;
                sdio_oe_o = rd_frame;
                sdio_o    = sdo;
                csn_oe_o  = 1'b0;
                csn_o     = alert;
            end
        endcase
    end

    p_idle_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && !par_mode_i) |-> !sdio_oe_o);

    p_alert_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_i && !par_mode_i) |-> (csn_oe_o && csn_o == (stat_i[0] | stat_i[1])));

    p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_fall && dir_i && ser_en && $past(ser_en)) |-> (sdio_o == $past(stat_i[0])));

    p_par_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode_i |=> $stable(cmd_q));

endmodule

// File: tb/test_slic_ctl_port.sv
module test_slic_ctl_port;

    localparam int CW = 8;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0, sdi = 1'b0, dir = 1'b0, csn = 1'b1;
    logic          irq = 1'b0, par = 1'b0;
    logic [SW-1:0] stat = '0;
    logic          sdo, sdo_oe, csn_out, csn_oe;
    logic [CW-1:0] cmd;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    slic_ctl_port #(.CMD_W(CW), .STAT_W(SW)) i_slic_ctl_port (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdio_i(sdi), .sdio_o(sdo),
        .sdio_oe_o(sdo_oe), .dir_i(dir), .csn_i(csn), .csn_o(csn_out),
        .csn_oe_o(csn_oe), .irq_mode_i(irq), .par_mode_i(par),
        .stat_i(stat), .cmd_o(cmd)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit     mbits[$];
    bit     mrd[$];
    bit     mbad = 0;
    int     mcmd = 0;
    bit     p_sclk = 0, p_csn = 0;

    always @(posedge clk) begin
        bit ser;
        int pc;
        bit e_oe, e_sdo, e_csoe, e_cs;
        if (!rst_n) begin
            mbits.delete(); mrd.delete(); mbad = 0; mcmd = 0; p_sclk = 0; p_csn = 0;
        end else begin
            ser = !irq && !par;
            if (csn) begin
                if (!p_csn && !mbad && mbits.size() == CW) begin
                    mcmd = 0;
                    foreach (mbits[i]) mcmd |= int'(mbits[i]) << i;
                end
                mbits.delete();
                mbad = 0;
            end else if (!ser || dir) begin
                mbad = 1;
            end else if (sclk && !p_sclk) begin
                if (mbits.size() <= CW) mbits.push_back(sdi);
            end
            if (!(ser && !csn && dir)) begin
                mrd.delete();
                for (int i = 0; i < SW; i++) mrd.push_back(stat[i]);
            end else if (!sclk && p_sclk && mrd.size() > 0) begin
                void'(mrd.pop_front());
            end
            p_sclk = sclk;
            p_csn  = csn;
            #1;
            ser = !irq && !par;
            pc  = par ? (int'(sclk) << 2 | int'(irq) << 1 | int'(dir)) : mcmd;
            e_oe   = par ? 1'b1 : (ser && !csn && dir);
            e_sdo  = par ? stat[1] : (mrd.size() > 0 ? mrd[0] : 1'b0);
            e_csoe = par || irq;
            e_cs   = par ? stat[0] : (stat[0] | stat[1]);
            chk("R2 model cmd_o", 32'(cmd), 32'(pc));
            chk("R7 model sdio_oe", 32'(sdo_oe), 32'(e_oe));
            if (e_oe) chk("R5 model sdio_o", 32'(sdo), 32'(e_sdo));
            chk("R8 model csn_oe", 32'(csn_oe), 32'(e_csoe));
            if (e_csoe) chk("R8 model csn_o", 32'(csn_out), 32'(e_cs));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] w, int n, bit glitch);
        dir = 1'b0; csn = 1'b0; cyc(2);
        for (int i = 0; i < n; i++) begin
            sdi = w[i]; sclk = 1'b0; cyc(2);
            if (glitch && i == 3) begin dir = 1'b1; cyc(1); dir = 1'b0; end
            sclk = 1'b1; cyc(2);
        end
        sclk = 1'b0; cyc(2);
        csn = 1'b1; cyc(3);
    endtask

    task automatic rd(int n, output logic [7:0] got);
        got = '0;
        dir = 1'b1; csn = 1'b0; cyc(2);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; cyc(2);
            got[i] = sdo;
            sclk = 1'b0; cyc(2);
        end
        csn = 1'b1; cyc(1);
        dir = 1'b0; cyc(2);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] g;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R10 reset cmd", 32'(cmd), 32'h0);
        chk("R10 reset sdio_oe", 32'(sdo_oe), 32'h0);
        chk("R10 reset csn_oe", 32'(csn_oe), 32'h0);

        wr(16'h00A5, 8, 0);
        chk("R1 write A5", 32'(cmd), 32'hA5);
        wr(16'h003C, 8, 0);
        chk("R2 write 3C", 32'(cmd), 32'h3C);
        wr(16'h00FF, 7, 0);
        chk("R3 seven clocks discarded", 32'(cmd), 32'h3C);
        wr(16'h01FF, 9, 0);
        chk("R3 nine clocks discarded", 32'(cmd), 32'h3C);
        wr(16'h0081, 8, 1);
        chk("R4 direction glitch discarded", 32'(cmd), 32'h3C);
        wr(16'h0081, 8, 0);
        chk("R1 write 81", 32'(cmd), 32'h81);

        chk("R7 idle data pin off", 32'(sdo_oe), 32'h0);
        dir = 1'b0; csn = 1'b0; cyc(2);
        chk("R7 write frame data pin off", 32'(sdo_oe), 32'h0);
        csn = 1'b1; cyc(2);

        stat = 5'b10110; cyc(2);
        rd(6, g);
        chk("R5 full read with zero fill", 32'(g), 32'h16);
        stat = 5'b01011; cyc(2);
        rd(2, g);
        chk("R6 partial read", 32'(g), 32'h03);
        stat = 5'b10100; cyc(2);
        rd(5, g);
        chk("R6 restart after partial", 32'(g), 32'h14);

        irq = 1'b1; stat = 5'b00000; cyc(2);
        chk("R8 alert enable", 32'(csn_oe), 32'h1);
        chk("R8 alert quiet", 32'(csn_out), 32'h0);
        stat = 5'b00010; cyc(1);
        chk("R8 alert ground key", 32'(csn_out), 32'h1);
        stat = 5'b00001; cyc(1);
        chk("R8 alert off hook", 32'(csn_out), 32'h1);
        stat = 5'b11100; cyc(1);
        chk("R8 alert other bits", 32'(csn_out), 32'h0);
        wr(16'h0055, 8, 0);
        irq = 1'b0; cyc(2);
        chk("R8 frame in alert mode ignored", 32'(cmd), 32'h81);

        par = 1'b1; dir = 1'b1; sclk = 1'b1; stat = 5'b00010; cyc(1);
        chk("R9 parallel cmd", 32'(cmd), 32'h05);
        chk("R9 parallel hook pin", 32'(csn_out), 32'h0);
        chk("R9 parallel gkey pin", 32'(sdo), 32'h1);
        irq = 1'b1; sclk = 1'b0; dir = 1'b0; stat = 5'b00001; cyc(1);
        chk("R9 parallel cmd timing", 32'(cmd), 32'h02);
        chk("R9 parallel hook follows", 32'(csn_out), 32'h1);
        par = 1'b0; irq = 1'b0; cyc(2);
        chk("R9 leave parallel restores", 32'(cmd), 32'h81);

        cyc(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule